// File: doc/BRIEF.md
# Shadowed Nonvolatile Memory Transfer Controller

This block fronts a byte-wide memory built from a volatile working array and a nonvolatile shadow array of the same size, paired location for location. Four active-low strobes (chip select, write strobe, read strobe, nonvolatile select) are decoded on every idle clock into an ordinary read, an ordinary write, or a host-requested recall that reloads the entire working array from the shadow.

Whole-array transfers move one location per clock. A recall runs on host command and at every power-up. A store, which copies the working array into the shadow, runs either when an external command-sequence detector raises `store_req` or automatically when the low-supply flag rises while the automatic-store arm latch is set. While a transfer runs, the block is busy for a parameterized number of cycles and ignores every bus operation and request; a dropped request is reported by a one-cycle pulse. Supply sensing is reduced to two digital inputs: a power-good level and a low-supply flag.

Top module: `nvshadow_ctrl`

## Requirements
- R1: The working array holds 2^ADDR_W words of DATA_W bits (2048 x 8 by default, 11 address bits). A read is decoded when cs_n=0, rd_n=0, wr_n=1 and nv_n=1 in an idle cycle. One cycle later, dout_en is 1 and dout carries the word at addr.
- R2: A write is decoded when cs_n=0, wr_n=0 and nv_n=1 in an idle cycle. The write stores din at addr, whatever rd_n is.
- R3: dout_en is 0 in any cycle that does not follow an idle cycle with a decoded read. This includes every cycle after cs_n=1, rd_n=1 or nv_n=0.
- R4: In an idle cycle with power good, cs_n=0, rd_n=0, nv_n=0 and wr_n=1 start a recall. busy is then 1 for RECALL_CYCLES cycles, after which every working location equals its shadow location.
- R5: When pwr_ok is 1 in the powered-down phase (after reset or after a power loss), a recall starts. busy stays 1 until the recall completes. The recall clears the automatic-store arm latch.
- R6: store_req in an idle cycle with rd_n=1 starts a store. busy is then 1 for STORE_CYCLES cycles, after which every shadow location equals its working location. store_req with rd_n=0 has no effect.
- R7: arm_req sets the automatic-store arm latch and disarm_req clears it; disarm wins when both arrive together. A 0-to-1 change of supply_low in an idle cycle starts a store only while the latch is set.
- R8: While busy is 1 from a transfer, reads, writes, recalls, store_req, arm_req, disarm_req and supply_low rises are ignored and not queued. Each cycle holding any such request produces req_dropped=1 one cycle later.
- R9: low_alert equals supply_low delayed by one clock.
- R10: Reset enters the powered-down phase with busy=1, dout_en=0 and req_dropped=0. pwr_ok=0 in an idle cycle returns the block to the powered-down phase, where busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwr_ok | input | 1 | Supply good level |
| supply_low | input | 1 | Supply below auto-store threshold |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read/output strobe, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| store_req | input | 1 | Store request from command detector |
| arm_req | input | 1 | Set automatic-store arm latch |
| disarm_req | input | 1 | Clear automatic-store arm latch |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Data bus drive enable |
| busy | output | 1 | Transfer running or powered down |
| low_alert | output | 1 | Low-supply status |
| req_dropped | output | 1 | Request ignored during a transfer |

## Verification
The hardest situation to reach is a request that lands in the middle of a multi-thousand-cycle transfer: a write, a read, a fresh store_req, and an arm or disarm. Each must be shown to leave no trace once the transfer ends. The stimulus issues these strobes a few cycles after starting a store and a recall. It then reads back locations whose old and new values differ, so a leaked write or a re-run transfer would change the data seen. The power-loss path is reached by dropping pwr_ok while armed and then raising supply_low after the power-up recall, which must not store.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_IDLE   = 2'd1,
        PH_RECALL = 2'd2,
        PH_STORE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic rc;
    } bus_op_t;

    function automatic bus_op_t decode_bus(input logic cs_n, input logic wr_n,
                                           input logic rd_n, input logic nv_n);
        bus_op_t r;
        r.rd = !cs_n && !rd_n && wr_n && nv_n;
        r.wr = !cs_n && !wr_n && nv_n;
        r.rc = !cs_n && !rd_n && !nv_n && wr_n;
        return r;
    endfunction

endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int AW            = 11,
    parameter int RECALL_CYCLES = 2048,
    parameter int STORE_CYCLES  = 2560
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          supply_low,
    input  bus_op_t       op,
    input  logic          rd_n,
    input  logic          store_req,
    input  logic          arm_req,
    input  logic          disarm_req,
    output phase_e        phase,
    output logic [AW-1:0] step,
    output logic          copy_en,
    output logic          busy,
    output logic          armed,
    output logic          low_seen,
    output logic          dropped
);
    localparam int DEPTH      = 1 << AW;
    localparam int RECALL_LEN = (RECALL_CYCLES < DEPTH) ? DEPTH : RECALL_CYCLES;
    localparam int STORE_LEN  = (STORE_CYCLES < DEPTH) ? DEPTH : STORE_CYCLES;
    localparam int LEN_MAX    = (RECALL_LEN > STORE_LEN) ? RECALL_LEN : STORE_LEN;
    localparam int CW         = $clog2(LEN_MAX + 1);
    localparam logic [CW-1:0] RECALL_LAST = CW'(RECALL_LEN - 1);
    localparam logic [CW-1:0] STORE_LAST  = CW'(STORE_LEN - 1);
    localparam logic [CW-1:0] DEPTH_C     = CW'(DEPTH);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          arm;
        logic          low;
        logic          drop;
    } seq_t;

    seq_t s_q, s_d;
    logic low_rise;
    logic [CW-1:0] last_cnt;

    always_comb begin
        s_d      = s_q;
        s_d.drop = 1'b0;
        s_d.low  = supply_low;
        low_rise = supply_low && !s_q.low;
        last_cnt = (s_q.ph == PH_STORE) ? STORE_LAST : RECALL_LAST;

        case (s_q.ph)
            PH_OFF: begin
                if (pwr_ok) begin
                    s_d.ph  = PH_RECALL;
                    s_d.cnt = '0;
                    s_d.arm = 1'b0;
                end
            end
            PH_IDLE: begin
                s_d.cnt = '0;
                if (!pwr_ok) begin
                    s_d.ph = PH_OFF;
                end else if (s_q.arm && low_rise) begin
                    s_d.ph = PH_STORE;
                end else if (store_req && rd_n) begin
                    s_d.ph = PH_STORE;
                end else if (op.rc) begin
                    s_d.ph = PH_RECALL;
                end else begin
                    if (arm_req)    s_d.arm = 1'b1;
                    if (disarm_req) s_d.arm = 1'b0;
                end
            end
            default: begin
                s_d.drop = store_req || arm_req || disarm_req || (s_q.arm && low_rise)
                         || op.rd || op.wr || op.rc;
                if (s_q.cnt == last_cnt) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_OFF, cnt: '0, arm: 1'b0, low: 1'b0, drop: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.ph;
    assign step     = s_q.cnt[AW-1:0];
    assign copy_en  = ((s_q.ph == PH_RECALL) || (s_q.ph == PH_STORE)) && (s_q.cnt < DEPTH_C);
    assign busy     = (s_q.ph != PH_IDLE);
    assign armed    = s_q.arm;
    assign low_seen = s_q.low;
    assign dropped  = s_q.drop;

endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int RECALL_CYCLES = 2048,
    parameter int STORE_CYCLES  = 2560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              supply_low,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              nv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              store_req,
    input  logic              arm_req,
    input  logic              disarm_req,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy,
    output logic              low_alert,
    output logic              req_dropped
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              en;
    } out_t;

    bus_op_t           op;
    phase_e            phase;
    logic [ADDR_W-1:0] step;
    logic              copy_en;
    logic              armed;
    logic              idle;
    logic              ram_we, shd_we;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata, shd_rdata;
    out_t              out_q, out_d;

    assign op   = decode_bus(cs_n, wr_n, rd_n, nv_n);
    assign idle = (phase == PH_IDLE);

    nvs_seq #(
        .AW            (ADDR_W),
        .RECALL_CYCLES (RECALL_CYCLES),
        .STORE_CYCLES  (STORE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_ok),
        .supply_low (supply_low),
        .op         (op),
        .rd_n       (rd_n),
        .store_req  (store_req),
        .arm_req    (arm_req),
        .disarm_req (disarm_req),
        .phase      (phase),
        .step       (step),
        .copy_en    (copy_en),
        .busy       (busy),
        .armed      (armed),
        .low_seen   (low_alert),
        .dropped    (req_dropped)
    );

    // Working array: host writes when idle, shadow data during recall.
    assign ram_we    = (idle && op.wr) || ((phase == PH_RECALL) && copy_en);
    assign ram_waddr = (phase == PH_RECALL) ? step : addr;
    assign ram_wdata = (phase == PH_RECALL) ? shd_rdata : din;
    assign ram_raddr = (phase == PH_STORE) ? step : addr;

    // Shadow array: written only while a store walks the addresses.
    assign shd_we = (phase == PH_STORE) && copy_en;

    nvs_array #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    nvs_array #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
        .clk   (clk),
        .we    (shd_we),
        .waddr (step),
        .wdata (ram_rdata),
        .raddr (step),
        .rdata (shd_rdata)
    );

    always_comb begin
        out_d    = out_q;
        out_d.en = idle && op.rd;
        if (idle && op.rd) begin
            out_d.data = ram_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout    = out_q.data;
    assign dout_en = out_q.en;

endmodule

// File: rtl/nvshadow_chk.sv
module nvshadow_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic supply_low,
    input logic cs_n,
    input logic wr_n,
    input logic rd_n,
    input logic nv_n,
    input logic store_req,
    input logic busy,
    input logic dout_en,
    input logic low_alert,
    input logic req_dropped,
    input logic armed
);
    AST_ALERT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ok || !pwr_ok |=> (low_alert == $past(supply_low))); // R9

    AST_BUS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!cs_n && !rd_n && wr_n && nv_n)); // R3

    AST_NO_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_en); // R8

    AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_dropped |-> $past(busy)); // R8

    AST_BLOCKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_ok && store_req && !rd_n && !(armed && supply_low && !low_alert)
         && !(!cs_n && !nv_n && wr_n)) |=> !busy); // R6

    AST_DISARMED_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_ok && !armed && !store_req && !(!cs_n && !rd_n && !nv_n && wr_n))
        |=> !busy); // R7

    AST_POWER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pwr_ok) |=> busy); // R10

endmodule

bind nvshadow_ctrl nvshadow_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok      (pwr_ok),
    .supply_low  (supply_low),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .rd_n        (rd_n),
    .nv_n        (nv_n),
    .store_req   (store_req),
    .busy        (busy),
    .dout_en     (dout_en),
    .low_alert   (low_alert),
    .req_dropped (req_dropped),
    .armed       (armed)
);

// File: tb/nvshadow_ctrl_tb.sv
module nvshadow_ctrl_tb;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int RC_LEN = 2048;
    localparam int ST_LEN = 2560;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1, supply_low = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, nv_n = 1'b1;
    logic store_req = 1'b0, arm_req = 1'b0, disarm_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, busy, low_alert, req_dropped;

    always #5 clk = ~clk;

    nvshadow_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RECALL_CYCLES(RC_LEN), .STORE_CYCLES(ST_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .supply_low(supply_low),
        .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .nv_n(nv_n), .addr(addr), .din(din),
        .store_req(store_req), .arm_req(arm_req), .disarm_req(disarm_req),
        .dout(dout), .dout_en(dout_en), .busy(busy), .low_alert(low_alert),
        .req_dropped(req_dropped)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 powered down, 1 idle, 2 recall, 3 store.
    int m_ph = 0;
    int m_cnt = 0;
    bit m_arm = 0, m_low = 0, m_en = 0, m_drop = 0, m_dv = 0;
    int m_dout = 0;
    int mem[int];
    int shd[int];
    string m_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_arm = 0; m_low = 0; m_en = 0; m_drop = 0;
            m_tag = "R10";
        end else begin
            bit rise, rd, wr, rc;
            rise = supply_low && !m_low;
            rd = !cs_n && !rd_n && wr_n && nv_n;
            wr = !cs_n && !wr_n && nv_n;
            rc = !cs_n && !rd_n && !nv_n && wr_n;
            m_en = 0;
            m_drop = 0;
            if (m_ph == 0) begin
                if (pwr_ok) begin m_ph = 2; m_cnt = 0; m_arm = 0; m_tag = "R5"; end
            end else if (m_ph == 1) begin
                if (rd) begin
                    m_en = 1;
                    m_dv = mem.exists(int'(addr));
                    if (m_dv) m_dout = mem[int'(addr)];
                end
                if (wr) mem[int'(addr)] = int'(din);
                m_cnt = 0;
                if (!pwr_ok) begin m_ph = 0; m_tag = "R10"; end
                else if (m_arm && rise) begin m_ph = 3; m_tag = "R7"; end
                else if (store_req && rd_n) begin m_ph = 3; m_tag = "R6"; end
                else if (rc) begin m_ph = 2; m_tag = "R4"; end
                else begin
                    if (arm_req) m_arm = 1;
                    if (disarm_req) m_arm = 0;
                end
            end else begin
                m_drop = store_req || arm_req || disarm_req || (m_arm && rise) || rd || wr || rc;
                m_cnt++;
                if (m_cnt == ((m_ph == 3) ? ST_LEN : RC_LEN)) begin
                    if (m_ph == 3) shd = mem;
                    else mem = shd;
                    m_ph = 1;
                    m_cnt = 0;
                end
            end
            m_low = supply_low;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(busy === (m_ph != 1), m_tag, "busy", int'(busy), int'(m_ph != 1));
            chk(dout_en === m_en, "R3", "dout_en", int'(dout_en), int'(m_en));
            chk(req_dropped === m_drop, "R8", "req_dropped", int'(req_dropped), int'(m_drop));
            chk(low_alert === m_low, "R9", "low_alert", int'(low_alert), int'(m_low));
            if (m_en && m_dv)
                chk(int'(dout) == m_dout, "R1/R2", "dout", int'(dout), m_dout);
        end
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input bit c, input bit w, input bit r, input bit n, input int a, input int d,
                       input bit sr, input bit ar, input bit dr);
        @(negedge clk);
        cs_n = c; wr_n = w; rd_n = r; nv_n = n;
        addr = AW'(a); din = DW'(d);
        store_req = sr; arm_req = ar; disarm_req = dr;
    endtask

    task automatic idle_bus();
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic wait_ready();
        idle_bus();
        while (busy) @(negedge clk);
    endtask

    int alist[10] = '{0, 1, 2047, 1024, 5, 777, 1365, 682, 2046, 300};

    function automatic int pat(input int a, input int seed);
        return (a * 37 + seed) & 255;
    endfunction

    task automatic write_all(input int seed);     // R2 writes
        foreach (alist[i]) cyc(0, 0, 1, 1, alist[i], pat(alist[i], seed), 0, 0, 0);
        idle_bus();
    endtask

    task automatic read_all();                    // R1 reads, data checked by model
        foreach (alist[i]) cyc(0, 1, 0, 1, alist[i], 0, 0, 0, 0);
        idle_bus();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy === 1'b1, "R10", "busy in reset", int'(busy), 1);
        chk(dout_en === 1'b0, "R10", "dout_en in reset", int'(dout_en), 0);
        chk(req_dropped === 1'b0, "R10", "req_dropped in reset", int'(req_dropped), 0);
        rst_n = 1'b1;
        wait_ready();                                  // R5 power-up recall

        write_all(11);
        read_all();
        // R3 non-read decodes
        cyc(0, 1, 1, 1, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 1, 0, 0, 0, 0);                // R4 host recall (restores nothing written yet)
        wait_ready();
        write_all(11);

        // R6 store blocked while rd_n low
        cyc(1, 1, 0, 1, 0, 0, 1, 0, 0);
        idle_bus();
        repeat (3) idle_bus();

        // R6 host store, R8 traffic during it
        cyc(1, 1, 1, 1, 0, 0, 1, 0, 0);
        repeat (4) idle_bus();
        cyc(0, 0, 1, 1, 0, 99, 0, 0, 0);
        cyc(0, 1, 0, 1, 1, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 1, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0);
        wait_ready();
        read_all();

        // R4 host recall restores stored data, R8 disarm during it
        write_all(200);
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) idle_bus();
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 1);
        cyc(0, 0, 1, 1, 1, 7, 0, 0, 0);
        wait_ready();
        read_all();

        // R7 armed automatic store on supply_low rise, R9 alert
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0);
        write_all(50);
        @(negedge clk) supply_low = 1'b1;
        wait_ready();
        @(negedge clk) supply_low = 1'b0;
        write_all(70);
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
        wait_ready();
        read_all();

        // R7 disarmed: no store
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 1);
        write_all(90);
        @(negedge clk) supply_low = 1'b1;
        repeat (5) idle_bus();
        @(negedge clk) supply_low = 1'b0;
        // R7 arm and disarm together: disarm wins
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 1);
        @(negedge clk) supply_low = 1'b1;
        repeat (5) idle_bus();
        @(negedge clk) supply_low = 1'b0;
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
        wait_ready();
        read_all();

        // R10 power loss, R5 power-up recall clears arm
        cyc(1, 1, 1, 1, 0, 0, 0, 1, 0);
        write_all(33);
        @(negedge clk) pwr_ok = 1'b0;
        repeat (5) idle_bus();
        @(negedge clk) pwr_ok = 1'b1;
        wait_ready();
        read_all();
        write_all(44);
        @(negedge clk) supply_low = 1'b1;
        repeat (5) idle_bus();
        @(negedge clk) supply_low = 1'b0;
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
        wait_ready();
        read_all();
        repeat (3) idle_bus();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule